// File: doc/BRIEF.md
# Banked Multi-MISR Response Compactor

This block compacts scan-out slices into sixteen narrow multiple-input signature registers instead of one wide one. The scan chains are split into eight equal groups, and every register folds in exactly two groups. The group pairs differ from register to register, so when unknown or must-observe cells bunch up in one group, some register that does not see that group can still be used. The sixteen registers form two banks of eight. Compaction runs one slice per enabled cycle until the controller stops it. A restart pulse then clears every register so the next signature can start.

To read a signature, each bank takes a lane select and a combination mask. The selected register is ANDed with the mask and reduced to one parity bit. A mask that picks register bits whose unknown dependencies cancel gives a bit that is free of unknowns. The two bank bits are compared in the same cycle against two expected bits, and any mismatch sets a sticky fail flag. Choosing the selects and masks, and deciding when to stop compacting, belong to the tester and the pattern generator, not to this block.

Top module: `banked_misr_compactor`

## Requirements
- R1: While rst_ni is low, and immediately after it, all sixteen registers hold zero and fail_o is 0. So chk_o is 2'b00 for any select and mask.
- R2: An enabled cycle (comp_en_i=1, restart_i=0) updates each 16-bit register s to ({s[14:0],1'b0} ^ (s[15] ? 16'h1021 : 0) ^ d). Here d is zero-extended from {chains of the high group, chains of the low group}, with the low group in d[3:0]. Chain j of group g is slice_i[g*4+j].
- R3: Register pairs are fixed by a parameter. The 0-based default, listed as (low,high) for lanes 0..15, is: (0,1) (4,5) (0,2) (4,6) (0,4) (2,6) (0,5) (2,7) (2,3) (6,7) (1,3) (5,7) (1,5) (3,7) (1,4) (3,6).
- R4: When comp_en_i=0 and restart_i=0, every register keeps its value, whatever slice_i holds.
- R5: restart_i=1 clears all sixteen registers at the next clock edge, even when comp_en_i=1; that slice is discarded.
- R6: chk_o[0] equals the XOR of (lane sel_a_i register AND comb_a_i), over lanes 0..7. It follows a change of select or mask in the same cycle, without waiting for a clock edge.
- R7: chk_o[1] equals the XOR of (lane 8+sel_b_i register AND comb_b_i), formed the same way as R6.
- R8: When check_en_i=1 and chk_o differs from exp_i in either bit, fail_o is 1 from the next clock edge. When check_en_i=0, exp_i has no effect.
- R9: Once set, fail_o stays 1 until rst_ni goes low; restart_i does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slice_i | input | 32 | Current scan slice, 8 groups of 4 chains |
| comp_en_i | input | 1 | Fold the slice into all registers |
| restart_i | input | 1 | Clear all registers for a new signature |
| sel_a_i | input | 3 | Lane select, bank A (lanes 0..7) |
| comb_a_i | input | 16 | Combination mask, bank A |
| sel_b_i | input | 3 | Lane select, bank B (lanes 8..15) |
| comb_b_i | input | 16 | Combination mask, bank B |
| check_en_i | input | 1 | Compare chk_o against exp_i this cycle |
| exp_i | input | 2 | Expected check bits {bank B, bank A} |
| chk_o | output | 2 | Masked parity bits {bank B, bank A} |
| fail_o | output | 1 | Sticky mismatch flag |

## Verification
Register contents become visible on chk_o one clock edge after the slice or restart that changes them. A new select or mask reaches chk_o with no edge at all. The bench therefore drives each input set just after a falling edge and checks chk_o one time step later against a model updated at the previous rising edge. A compare registers its result at the following rising edge, so fail_o is checked at the next falling edge. Random slices, enables, restarts and masks run alongside directed tests. The directed tests cover pairing, holding, restarting under enable, masked mismatches and stickiness across restarts.

// File: rtl/mmc_pkg.sv
package mmc_pkg;

  function automatic logic [15:0] unused_pkg_marker();
    return 16'h0;
  endfunction

  // Masked parity reduction of one register
  function automatic logic masked_parity(input logic [63:0] state, input logic [63:0] mask);
    return ^(state & mask);
  endfunction

endpackage

// File: rtl/misr_lane.sv
module misr_lane #(
  parameter int          W    = 16,
  parameter int          IN_W = 8,
  parameter logic [W-1:0] POLY = 16'h1021
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            clr_i,
  input  logic [IN_W-1:0] data_i,
  output logic [W-1:0]    state_o
);

  logic [W-1:0] state_q, state_d, din;

  assign din = W'(data_i);

  always_comb begin
    state_d = state_q;
    if (clr_i)     state_d = '0;
    else if (en_i) state_d = {state_q[W-2:0], 1'b0} ^ (state_q[W-1] ? POLY : '0) ^ din;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= '0;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  a_r5_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (state_o == '0));

  a_r4_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(state_o));

endmodule

// File: rtl/bank_reduce.sv
module bank_reduce #(
  parameter int W = 16,
  parameter int N = 8,
  parameter int SEL_W = $clog2(N)
) (
  input  logic [N-1:0][W-1:0] lanes_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [W-1:0]        comb_i,
  output logic                bit_o
);

  logic [W-1:0] picked;

  always_comb begin
    picked = '0;
    for (int i = 0; i < N; i++)
      if (SEL_W'(i) == sel_i) picked = lanes_i[i];
  end

  assign bit_o = mmc_pkg::masked_parity(64'(picked), 64'(comb_i));

endmodule

// File: rtl/sig_check.sv
module sig_check #(
  parameter int NB = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [NB-1:0] chk_i,
  input  logic [NB-1:0] exp_i,
  output logic          fail_o
);

  logic fail_q;
  logic mismatch;

  assign mismatch = en_i && (chk_i != exp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       fail_q <= 1'b0;
    else if (mismatch) fail_q <= 1'b1;
  end

  assign fail_o = fail_q;

  a_r8_mismatch_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (chk_i != exp_i)) |=> fail_o);

  a_r9_fail_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> fail_o);

  a_r8_fail_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> $past(en_i && (chk_i != exp_i)));

endmodule

// File: rtl/banked_misr_compactor.sv
module banked_misr_compactor #(
  parameter int GROUPS         = 8,
  parameter int GROUP_W        = 4,
  parameter int MISR_W         = 16,
  parameter int LANES_PER_BANK = 8,
  parameter logic [MISR_W-1:0] POLY = 16'h1021,
  // entry k = {high group, low group}, lane 15 first
  parameter logic [2*LANES_PER_BANK*2*$clog2(GROUPS)-1:0] PAIRS = {
    6'd51, 6'd33, 6'd59, 6'd41, 6'd61, 6'd25, 6'd62, 6'd26,
    6'd58, 6'd40, 6'd50, 6'd32, 6'd52, 6'd16, 6'd44, 6'd8 }
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [GROUPS*GROUP_W-1:0]         slice_i,
  input  logic                              comp_en_i,
  input  logic                              restart_i,
  input  logic [$clog2(LANES_PER_BANK)-1:0] sel_a_i,
  input  logic [MISR_W-1:0]                 comb_a_i,
  input  logic [$clog2(LANES_PER_BANK)-1:0] sel_b_i,
  input  logic [MISR_W-1:0]                 comb_b_i,
  input  logic                              check_en_i,
  input  logic [1:0]                        exp_i,
  output logic [1:0]                        chk_o,
  output logic                              fail_o
);

  localparam int NUM_LANES = 2 * LANES_PER_BANK;
  localparam int GIDX_W    = $clog2(GROUPS);
  localparam int PAIR_W    = 2 * GIDX_W;
  localparam int IN_W      = 2 * GROUP_W;
  localparam int SEL_W     = $clog2(LANES_PER_BANK);

  logic [NUM_LANES-1:0][MISR_W-1:0] lane_state;

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    localparam int LO = int'(PAIRS[k*PAIR_W +: GIDX_W]);
    localparam int HI = int'(PAIRS[k*PAIR_W + GIDX_W +: GIDX_W]);
    logic [IN_W-1:0] lane_in;
    assign lane_in = {slice_i[HI*GROUP_W +: GROUP_W], slice_i[LO*GROUP_W +: GROUP_W]};

    misr_lane #(.W(MISR_W), .IN_W(IN_W), .POLY(POLY)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (comp_en_i),
      .clr_i   (restart_i),
      .data_i  (lane_in),
      .state_o (lane_state[k])
    );
  end

  logic [1:0] chk;

  bank_reduce #(.W(MISR_W), .N(LANES_PER_BANK), .SEL_W(SEL_W)) u_bank_a (
    .lanes_i (lane_state[LANES_PER_BANK-1:0]),
    .sel_i   (sel_a_i),
    .comb_i  (comb_a_i),
    .bit_o   (chk[0])
  );

  bank_reduce #(.W(MISR_W), .N(LANES_PER_BANK), .SEL_W(SEL_W)) u_bank_b (
    .lanes_i (lane_state[NUM_LANES-1:LANES_PER_BANK]),
    .sel_i   (sel_b_i),
    .comb_i  (comb_b_i),
    .bit_o   (chk[1])
  );

  assign chk_o = chk;

  sig_check #(.NB(2)) u_check (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (check_en_i),
    .chk_i  (chk),
    .exp_i  (exp_i),
    .fail_o (fail_o)
  );

  // R6/R7: a zero mask can never yield a set check bit
  always_comb begin
    if (rst_ni && comb_a_i == '0) a_r6_zero_mask: assert (chk_o[0] == 1'b0);
    if (rst_ni && comb_b_i == '0) a_r7_zero_mask: assert (chk_o[1] == 1'b0);
  end

endmodule

// File: tb/tb_banked_misr_compactor.sv
module tb_banked_misr_compactor;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] slice = '0;
  logic        en = 1'b0, rs = 1'b0, cen = 1'b0;
  logic [2:0]  sa = '0, sb = '0;
  logic [15:0] ca = '0, cb = '0;
  logic [1:0]  ex = '0;
  logic [1:0]  chk;
  logic        fail;

  int checks = 0, fails = 0;
  logic [15:0] ms [16];
  logic        mfail = 1'b0;
  int lo_g [16] = '{0,4,0,4,0,2,0,2, 2,6,1,5,1,3,1,3};
  int hi_g [16] = '{1,5,2,6,4,6,5,7, 3,7,3,7,5,7,4,6};

  always #5 clk = ~clk;

  banked_misr_compactor dut (
    .clk_i(clk), .rst_ni(rst_n), .slice_i(slice), .comp_en_i(en), .restart_i(rs),
    .sel_a_i(sa), .comb_a_i(ca), .sel_b_i(sb), .comb_b_i(cb),
    .check_en_i(cen), .exp_i(ex), .chk_o(chk), .fail_o(fail)
  );

  function automatic logic [15:0] lane_data(int k, logic [31:0] s);
    return {8'h00, s[hi_g[k]*4 +: 4], s[lo_g[k]*4 +: 4]};
  endfunction

  function automatic logic [15:0] step(logic [15:0] s, logic [15:0] d);
    return {s[14:0], 1'b0} ^ (s[15] ? 16'h1021 : 16'h0) ^ d;
  endfunction

  function automatic logic mbit(int bank, logic [2:0] sel, logic [15:0] comb);
    return ^(ms[bank*8 + int'(sel)] & comb);
  endfunction

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp_v);
    checks++;
    if (got !== exp_v) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp_v, $time);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < 16; k++) ms[k] = '0;
  endtask

  // one clock: model follows the driven inputs, returns at the falling edge
  task automatic tick();
    logic [1:0] mchk;
    @(posedge clk);
    mchk = {mbit(1, sb, cb), mbit(0, sa, ca)};
    if (cen && mchk != ex) mfail = 1'b1;
    if (rs) model_clear();
    else if (en) for (int k = 0; k < 16; k++) ms[k] = step(ms[k], lane_data(k, slice));
    @(negedge clk);
  endtask

  task automatic check_outs(string ta, string tb_, string tf);
    #1;
    check(ta, 16'(chk[0]), 16'(mbit(0, sa, ca)));
    check(tb_, 16'(chk[1]), 16'(mbit(1, sb, cb)));
    check(tf, 16'(fail), 16'(mfail));
  endtask

  task automatic scan_all_lanes(string tag, logic [15:0] comb);
    for (int s = 0; s < 8; s++) begin
      sa = 3'(s); sb = 3'(s); ca = comb; cb = comb;
      #1;
      check(tag, 16'(chk[0]), 16'(mbit(0, sa, ca)));
      check(tag, 16'(chk[1]), 16'(mbit(1, sb, cb)));
    end
  endtask

  task automatic random_cycles(int n, bit allow_restart);
    for (int i = 0; i < n; i++) begin
      slice = $urandom;
      en    = ($urandom % 4) != 0;
      rs    = allow_restart && (($urandom % 32) == 0);
      sa = 3'($urandom); sb = 3'($urandom);
      ca = 16'($urandom); cb = 16'($urandom);
      cen = ($urandom % 3) == 0;
      #1;
      ex = cen ? {mbit(1, sb, cb), mbit(0, sa, ca)} : ~{mbit(1, sb, cb), mbit(0, sa, ca)};
      check_outs("R6", "R7", "R8");
      tick();
    end
  endtask

  initial begin
    logic [1:0] held [8];
    void'($urandom(32'd12345));
    model_clear();
    repeat (3) @(negedge clk);
    // R1: reset state
    sa = 3'd5; sb = 3'd2; ca = 16'hFFFF; cb = 16'hFFFF;
    #1;
    check("R1", 16'(chk), 16'h0);
    check("R1", 16'(fail), 16'h0);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R1", 16'(chk), 16'h0);

    // R3: one group active at a time, one step from zero
    for (int g = 0; g < 8; g++) begin
      rs = 1'b1; en = 1'b0; tick(); rs = 1'b0;
      slice = 32'h1 << (g*4 + (g % 4)); en = 1'b1; tick(); en = 1'b0;
      for (int s = 0; s < 8; s++) begin
        sa = 3'(s); sb = 3'(s); ca = 16'hFFFF; cb = 16'hFFFF;
        #1;
        check("R3", 16'(chk[0]), 16'((lo_g[s] == g) || (hi_g[s] == g)));
        check("R3", 16'(chk[1]), 16'((lo_g[s+8] == g) || (hi_g[s+8] == g)));
      end
    end

    // R2: several enabled steps, single-bit masks probe state bits
    rs = 1'b1; tick(); rs = 1'b0;
    for (int i = 0; i < 24; i++) begin slice = $urandom; en = 1'b1; tick(); end
    en = 1'b0;
    for (int b = 0; b < 16; b++) scan_all_lanes("R2", 16'h1 << b);

    // R4: idle cycles with changing slice keep everything
    sa = 3'd3; sb = 3'd6; ca = 16'hA5C3; cb = 16'h3C5A;
    for (int s = 0; s < 8; s++) held[s] = {mbit(1, 3'(s), cb), mbit(0, 3'(s), ca)};
    for (int i = 0; i < 5; i++) begin slice = $urandom; en = 1'b0; tick(); end
    for (int s = 0; s < 8; s++) begin
      sa = 3'(s); sb = 3'(s);
      #1;
      check("R4", 16'(chk), 16'(held[s]));
    end

    // R5: restart wins over enable
    slice = 32'hFFFF_FFFF; en = 1'b1; rs = 1'b1; tick(); rs = 1'b0; en = 1'b0;
    for (int s = 0; s < 8; s++) begin
      sa = 3'(s); sb = 3'(s); ca = 16'hFFFF; cb = 16'hFFFF;
      #1;
      check("R5", 16'(chk), 16'h0);
    end

    random_cycles(700, 1'b1);

    // R8: wrong expectation ignored when compare disabled
    cen = 1'b0; ex = ~{mbit(1, sb, cb), mbit(0, sa, ca)}; en = 1'b0; tick();
    #1; check("R8", 16'(fail), 16'h0);
    // R8: a single-bit mismatch on bank B sets fail
    slice = 32'h0000_00F0; en = 1'b1; tick(); en = 1'b0;
    sb = 3'd1; cb = 16'hFFFF; sa = 3'd0; ca = 16'hFFFF;
    #1;
    cen = 1'b1; ex = {~mbit(1, sb, cb), mbit(0, sa, ca)};
    tick(); cen = 1'b0;
    #1; check("R8", 16'(fail), 16'h1);
    // R9: sticky through restart and more traffic
    rs = 1'b1; tick(); rs = 1'b0;
    #1; check("R9", 16'(fail), 16'h1);
    random_cycles(50, 1'b0);
    #1; check("R9", 16'(fail), 16'h1);

    // R1: reset again clears flag and registers
    rst_n = 1'b0; mfail = 1'b0; model_clear();
    #1;
    check("R1", 16'(fail), 16'h0);
    @(negedge clk); rst_n = 1'b1;
    scan_all_lanes("R1", 16'hFFFF);

    random_cycles(400, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule